// File: doc/BRIEF.md
# Dual-Source Output Buffer Arbiter

This block sits between two byte sources, a keyboard channel and an auxiliary (pointing device) channel, and the single host-visible output buffer they share. Each source holds a level high while it has a byte waiting. The arbiter keeps a two-bit pending mask from these levels and decides which source owns the shared buffer. It then produces the buffer-full status flags, mirrors of those flags for the output port, and one level-sensitive interrupt request per source.

Keyboard data always takes precedence. The auxiliary source is treated as the owner of the buffer only when it is the sole source with data. Only in that case does the auxiliary-full flag appear, the auxiliary interrupt become possible, and host data reads get steered to the auxiliary queue. The byte queues and the host bus decode live outside this block. For each host data read it emits a one-cycle read strobe toward the selected source, together with a level that says which source is selected.

All flags and interrupt levels are registered. A change on the source levels or on the mode inputs reaches them one clock later.

Top module: `obuf_arbiter`

## Requirements
- R1: While reset is asserted, statusMask, portMask, kbdIrq, auxIrq and readSelAux are all zero, whatever the source levels.
- R2: readSelAux is 1 exactly when, at the previous clock edge, auxAvail was 1 and kbdAvail was 0.
- R3: statusMask bit 0 (buffer full) is 1 in the cycle after an edge at which kbdAvail or auxAvail was 1, and 0 otherwise.
- R4: statusMask bit 5 (auxiliary full) is 1 in the cycle after an edge at which auxAvail was 1 and kbdAvail was 0, and 0 otherwise. In particular it stays 0 when both sources are pending.
- R5: auxIrq is 1 in the cycle after an edge at which auxAvail was 1, kbdAvail was 0 and modeAuxIrqEn was 1, and 0 otherwise.
- R6: kbdIrq is 1 in the cycle after an edge at which kbdAvail was 1, modeKbdIrqEn was 1 and modeKbdOff was 0, and 0 otherwise. Auxiliary data has no effect on it.
- R7: portMask bit 4 equals the buffer-full flag and portMask bit 5 equals the auxiliary-full flag.
- R8: In the same cycle as hostRd, exactly one read strobe pulses. auxReadStb pulses when readSelAux is 1, and kbdReadStb pulses otherwise. With hostRd low, both strobes are low.
- R9: Both interrupts are levels. Each drops in the cycle after the edge at which its condition became false.
- R10: All statusMask and portMask bits other than status bits 0 and 5 and port bits 4 and 5 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| kbdAvail | input | 1 | Keyboard source has data (level) |
| auxAvail | input | 1 | Auxiliary source has data (level) |
| modeKbdIrqEn | input | 1 | Mode: keyboard interrupt enable |
| modeAuxIrqEn | input | 1 | Mode: auxiliary interrupt enable |
| modeKbdOff | input | 1 | Mode: keyboard interface disabled (masks keyboard interrupt) |
| hostRd | input | 1 | Host data-port read, one cycle |
| statusMask | output | 8 | Status flag contribution: bit 0 buffer full, bit 5 auxiliary full |
| portMask | output | 8 | Output-port contribution: bit 4 buffer full, bit 5 auxiliary full |
| kbdIrq | output | 1 | Keyboard interrupt request level |
| auxIrq | output | 1 | Auxiliary interrupt request level |
| readSelAux | output | 1 | Host reads currently steered to the auxiliary source |
| kbdReadStb | output | 1 | Read strobe to keyboard queue |
| auxReadStb | output | 1 | Read strobe to auxiliary queue |

## Verification
The bound properties check on every cycle the one-clock relation from the source levels and mode inputs to the two flags, their port mirrors, both interrupts and the read selection. They also check that the two read strobes never pulse together. Only the bench scenarios show that the other mask bits stay clear and that reset holds everything low while sources are active. The bench scenarios also cover the precedence corners: both sources pending, an auxiliary-only byte with its interrupt disabled, and a disabled keyboard interface. They also show each interrupt falling the cycle after its source drains.

// File: rtl/obarb_pkg.sv
package obarb_pkg;

  // Decisions the control half hands to the datapath for the coming edge.
  typedef struct packed {
    logic anyPend;   // at least one source pending
    logic auxOnly;   // auxiliary is the sole pending source
    logic kbdPend;   // keyboard pending (wins over auxiliary)
  } arbStrobe_t;

  localparam int unsigned NUM_SRC = 2;
  localparam int unsigned SRC_KBD = 0;
  localparam int unsigned SRC_AUX = 1;

endpackage

// File: rtl/obarb_ctrl.sv
module obarb_ctrl
  import obarb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       kbdAvail,
  input  logic       auxAvail,
  input  logic       hostRd,
  output arbStrobe_t nextStb,
  output logic       readSelAux,
  output logic       kbdReadStb,
  output logic       auxReadStb
);

  localparam logic [NUM_SRC-1:0] AUX_ALONE = NUM_SRC'(1) << SRC_AUX;

  logic [NUM_SRC-1:0] pendNext;
  logic [NUM_SRC-1:0] pendQ;

  always_comb begin
    pendNext          = '0;
    pendNext[SRC_KBD] = kbdAvail;
    pendNext[SRC_AUX] = auxAvail;
  end

  // Precedence decision for the values the datapath will register.
  always_comb begin
    nextStb.anyPend = |pendNext;
    nextStb.auxOnly = (pendNext == AUX_ALONE);
    nextStb.kbdPend = pendNext[SRC_KBD];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= pendNext;
  end

  // Read steering uses the registered mask so the strobe matches the flags.
  assign readSelAux = (pendQ == AUX_ALONE);
  assign auxReadStb = hostRd &  readSelAux;
  assign kbdReadStb = hostRd & ~readSelAux;

endmodule

// File: rtl/obarb_dpath.sv
module obarb_dpath
  import obarb_pkg::*;
#(
  parameter int unsigned STAT_W    = 8,
  parameter int unsigned PORT_W    = 8,
  parameter int unsigned STAT_FULL = 0,
  parameter int unsigned STAT_AUX  = 5,
  parameter int unsigned PORT_FULL = 4,
  parameter int unsigned PORT_AUX  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  arbStrobe_t        nextStb,
  input  logic              modeKbdIrqEn,
  input  logic              modeAuxIrqEn,
  input  logic              modeKbdOff,
  output logic [STAT_W-1:0] statusMask,
  output logic [PORT_W-1:0] portMask,
  output logic              kbdIrq,
  output logic              auxIrq
);

  logic fullQ;
  logic auxFullQ;
  logic kbdIrqQ;
  logic auxIrqQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fullQ    <= 1'b0;
      auxFullQ <= 1'b0;
      kbdIrqQ  <= 1'b0;
      auxIrqQ  <= 1'b0;
    end else begin
      fullQ    <= nextStb.anyPend;
      auxFullQ <= nextStb.auxOnly;
      kbdIrqQ  <= nextStb.kbdPend & modeKbdIrqEn & ~modeKbdOff;
      auxIrqQ  <= nextStb.auxOnly & modeAuxIrqEn;
    end
  end

  generate
    for (genvar i = 0; i < STAT_W; i++) begin : g_stat
      if (i == STAT_FULL) begin : g_full
        assign statusMask[i] = fullQ;
      end else if (i == STAT_AUX) begin : g_aux
        assign statusMask[i] = auxFullQ;
      end else begin : g_zero
        assign statusMask[i] = 1'b0;
      end
    end
    for (genvar j = 0; j < PORT_W; j++) begin : g_port
      if (j == PORT_FULL) begin : g_full
        assign portMask[j] = fullQ;
      end else if (j == PORT_AUX) begin : g_aux
        assign portMask[j] = auxFullQ;
      end else begin : g_zero
        assign portMask[j] = 1'b0;
      end
    end
  endgenerate

  assign kbdIrq = kbdIrqQ;
  assign auxIrq = auxIrqQ;

endmodule

// File: rtl/obuf_arbiter.sv
module obuf_arbiter
  import obarb_pkg::*;
#(
  parameter int unsigned STAT_W    = 8,
  parameter int unsigned PORT_W    = 8,
  parameter int unsigned STAT_FULL = 0,
  parameter int unsigned STAT_AUX  = 5,
  parameter int unsigned PORT_FULL = 4,
  parameter int unsigned PORT_AUX  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              kbdAvail,
  input  logic              auxAvail,
  input  logic              modeKbdIrqEn,
  input  logic              modeAuxIrqEn,
  input  logic              modeKbdOff,
  input  logic              hostRd,
  output logic [STAT_W-1:0] statusMask,
  output logic [PORT_W-1:0] portMask,
  output logic              kbdIrq,
  output logic              auxIrq,
  output logic              readSelAux,
  output logic              kbdReadStb,
  output logic              auxReadStb
);

  arbStrobe_t arbStb;

  obarb_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .kbdAvail   (kbdAvail),
    .auxAvail   (auxAvail),
    .hostRd     (hostRd),
    .nextStb    (arbStb),
    .readSelAux (readSelAux),
    .kbdReadStb (kbdReadStb),
    .auxReadStb (auxReadStb)
  );

  obarb_dpath #(
    .STAT_W    (STAT_W),
    .PORT_W    (PORT_W),
    .STAT_FULL (STAT_FULL),
    .STAT_AUX  (STAT_AUX),
    .PORT_FULL (PORT_FULL),
    .PORT_AUX  (PORT_AUX)
  ) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .nextStb      (arbStb),
    .modeKbdIrqEn (modeKbdIrqEn),
    .modeAuxIrqEn (modeAuxIrqEn),
    .modeKbdOff   (modeKbdOff),
    .statusMask   (statusMask),
    .portMask     (portMask),
    .kbdIrq       (kbdIrq),
    .auxIrq       (auxIrq)
  );

endmodule

// File: rtl/obarb_checker.sv
module obarb_checker #(
  parameter int unsigned STAT_W    = 8,
  parameter int unsigned PORT_W    = 8,
  parameter int unsigned STAT_FULL = 0,
  parameter int unsigned STAT_AUX  = 5,
  parameter int unsigned PORT_FULL = 4,
  parameter int unsigned PORT_AUX  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              kbdAvail,
  input logic              auxAvail,
  input logic              modeKbdIrqEn,
  input logic              modeAuxIrqEn,
  input logic              modeKbdOff,
  input logic              hostRd,
  input logic [STAT_W-1:0] statusMask,
  input logic [PORT_W-1:0] portMask,
  input logic              kbdIrq,
  input logic              auxIrq,
  input logic              readSelAux,
  input logic              kbdReadStb,
  input logic              auxReadStb
);

  a_r2_sel_aux: assert property (@(posedge clk) disable iff (!rstN)
    (auxAvail && !kbdAvail) |=> readSelAux);
  a_r2_sel_kbd: assert property (@(posedge clk) disable iff (!rstN)
    !(auxAvail && !kbdAvail) |=> !readSelAux);
  a_r3_full_set: assert property (@(posedge clk) disable iff (!rstN)
    (kbdAvail || auxAvail) |=> statusMask[STAT_FULL]);
  a_r3_full_clr: assert property (@(posedge clk) disable iff (!rstN)
    !(kbdAvail || auxAvail) |=> !statusMask[STAT_FULL]);
  a_r4_aux_set: assert property (@(posedge clk) disable iff (!rstN)
    (auxAvail && !kbdAvail) |=> statusMask[STAT_AUX]);
  a_r4_aux_clr: assert property (@(posedge clk) disable iff (!rstN)
    kbdAvail |=> !statusMask[STAT_AUX]);
  a_r5_aux_irq: assert property (@(posedge clk) disable iff (!rstN)
    (auxAvail && !kbdAvail && modeAuxIrqEn) |=> auxIrq);
  a_r5_aux_irq_mask: assert property (@(posedge clk) disable iff (!rstN)
    !modeAuxIrqEn |=> !auxIrq);
  a_r6_kbd_irq: assert property (@(posedge clk) disable iff (!rstN)
    (kbdAvail && modeKbdIrqEn && !modeKbdOff) |=> kbdIrq);
  a_r6_kbd_off: assert property (@(posedge clk) disable iff (!rstN)
    modeKbdOff |=> !kbdIrq);
  a_r7_port_aux: assert property (@(posedge clk) disable iff (!rstN)
    (auxAvail && !kbdAvail) |=> (portMask[PORT_AUX] && portMask[PORT_FULL]));
  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({kbdReadStb, auxReadStb}));
  a_r8_rd_served: assert property (@(posedge clk) disable iff (!rstN)
    hostRd |-> (kbdReadStb || auxReadStb));
  a_r9_kbd_drop: assert property (@(posedge clk) disable iff (!rstN)
    !kbdAvail |=> !kbdIrq);
  a_r9_aux_drop: assert property (@(posedge clk) disable iff (!rstN)
    !auxAvail |=> !auxIrq);

endmodule

bind obuf_arbiter obarb_checker #(
  .STAT_W    (STAT_W),
  .PORT_W    (PORT_W),
  .STAT_FULL (STAT_FULL),
  .STAT_AUX  (STAT_AUX),
  .PORT_FULL (PORT_FULL),
  .PORT_AUX  (PORT_AUX)
) u_chk (.*);

// File: tb/obuf_arbiter_bench.sv
module obuf_arbiter_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       kbdAvail = 1'b0;
  logic       auxAvail = 1'b0;
  logic       modeKbdIrqEn = 1'b0;
  logic       modeAuxIrqEn = 1'b0;
  logic       modeKbdOff = 1'b0;
  logic       hostRd = 1'b0;
  logic [7:0] statusMask;
  logic [7:0] portMask;
  logic       kbdIrq;
  logic       auxIrq;
  logic       readSelAux;
  logic       kbdReadStb;
  logic       auxReadStb;

  int checks = 0;
  int errors = 0;
  logic prevK = 1'b0;
  logic prevA = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  obuf_arbiter u_obuf_arbiter (
    .clk          (clk),
    .rstN         (rstN),
    .kbdAvail     (kbdAvail),
    .auxAvail     (auxAvail),
    .modeKbdIrqEn (modeKbdIrqEn),
    .modeAuxIrqEn (modeAuxIrqEn),
    .modeKbdOff   (modeKbdOff),
    .hostRd       (hostRd),
    .statusMask   (statusMask),
    .portMask     (portMask),
    .kbdIrq       (kbdIrq),
    .auxIrq       (auxIrq),
    .readSelAux   (readSelAux),
    .kbdReadStb   (kbdReadStb),
    .auxReadStb   (auxReadStb)
  );

  function automatic logic [7:0] expStatus(logic k, logic a);
    logic [7:0] e = '0;
    e[0] = k | a;
    e[5] = a & ~k;
    return e;
  endfunction

  function automatic logic [7:0] expPort(logic k, logic a);
    logic [7:0] e = '0;
    e[4] = k | a;
    e[5] = a & ~k;
    return e;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check combinational strobes, then the
  // registered outputs just after the next rising edge.
  task automatic step(logic k, logic a, logic ki, logic ai, logic off, logic rd);
    logic sel;
    @(negedge clk);
    kbdAvail = k; auxAvail = a;
    modeKbdIrqEn = ki; modeAuxIrqEn = ai; modeKbdOff = off; hostRd = rd;
    #1;
    sel = prevA & ~prevK;
    check("R2 readSelAux", {7'd0, readSelAux}, {7'd0, sel});
    check("R8 kbdReadStb", {7'd0, kbdReadStb}, {7'd0, rd & ~sel});
    check("R8 auxReadStb", {7'd0, auxReadStb}, {7'd0, rd & sel});
    @(posedge clk);
    #1;
    check("R3/R4 statusMask", statusMask & 8'h21, expStatus(k, a));
    check("R10 status spare bits", statusMask & ~8'h21, 8'h00);
    check("R7 portMask", portMask, expPort(k, a));
    check("R6 kbdIrq", {7'd0, kbdIrq}, {7'd0, k & ki & ~off});
    check("R5 auxIrq", {7'd0, auxIrq}, {7'd0, a & ~k & ai});
    prevK = k; prevA = a;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [5:0] r;
    void'($urandom(32'd20240611));
    // R1: reset holds outputs low with sources active
    kbdAvail = 1'b1; auxAvail = 1'b1; modeKbdIrqEn = 1'b1; modeAuxIrqEn = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 statusMask", statusMask, 8'h00);
    check("R1 portMask", portMask, 8'h00);
    check("R1 irqs", {6'd0, kbdIrq, auxIrq}, 8'h00);
    check("R1 readSelAux", {7'd0, readSelAux}, 8'h00);
    @(negedge clk);
    kbdAvail = 1'b0; auxAvail = 1'b0;
    rstN = 1'b1;

    // Directed corners
    step(1, 1, 1, 1, 0, 1);  // R4: both pending, keyboard wins
    check("R4 both pending aux flag", {7'd0, statusMask[5]}, 8'h00);
    step(0, 1, 1, 0, 0, 1);  // R5: aux alone, irq disabled
    check("R5 aux irq masked", {7'd0, auxIrq}, 8'h00);
    step(0, 1, 1, 1, 0, 1);  // R8: read goes to aux
    check("R8 aux strobe on aux-only", {7'd0, auxReadStb}, 8'h01);
    step(0, 0, 1, 1, 0, 0);  // R9: aux drained
    check("R9 aux irq drop", {7'd0, auxIrq}, 8'h00);
    step(1, 0, 1, 1, 0, 0);
    check("R6 kbd irq on", {7'd0, kbdIrq}, 8'h01);
    step(1, 0, 1, 1, 1, 0);  // R6: keyboard interface disabled
    check("R6 kbd irq off by disable", {7'd0, kbdIrq}, 8'h00);
    step(1, 0, 1, 1, 0, 0);
    step(0, 0, 1, 1, 0, 1);  // R9: keyboard drained
    check("R9 kbd irq drop", {7'd0, kbdIrq}, 8'h00);
    step(1, 1, 1, 1, 0, 0);
    check("R6 aux has no effect on kbd irq", {7'd0, kbdIrq}, 8'h01);

    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      r = 6'($urandom);
      step(r[0], r[1], r[2] | r[5], r[3], r[4] & r[5], 1'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule